// File: doc/BRIEF.md
# Supply Supervisor Reset Generator with Memory Enable Gating

This block produces the processor reset for a supply supervisor. Three conditions request a reset: the supply sits below its reset threshold, the supply sits below the backup battery, or the watchdog reports a timeout. While any condition is present the reset is held active. Once all conditions have cleared, the reset stays active for a minimum time counted in ticks of a slow timebase. It is then released. A watchdog timeout is a one-cycle request, so it yields one reset pulse of that same minimum width.

Two reset outputs are provided, one active-low and one active-high, and they are always complementary. A low-line flag reports the supply comparator directly, with no stretching. A memory chip-enable (active-low) passes through a gate that forces it inactive whenever the supply is low, which blocks writes while power is failing. The comparator flags come from analog circuits outside the block and are resynchronised inside it. The watchdog pulse and the timebase tick are expected to be synchronous to the clock already.

Top module: `supv_reset_gen`

## Requirements
- R1: While the synchronised low-supply flag is set, both reset outputs stay active (reset_n_o = 0, reset_o = 1), however many ticks arrive.
- R2: While the below-battery flag is set and the supply is above threshold, reset stays active, low_line_n_o stays 1 and ce_out_n_o still follows ce_in_n_i.
- R3: After every condition has cleared, reset stays active until the stretch has counted PULSE ticks. PULSE is PULSE_SHORT_TICKS (default 50) when LONG_PULSE = 0, and PULSE_LONG_TICKS (default 200) when LONG_PULSE = 1. Only ticks that arrive while stretching count, and release happens at the clock edge that samples the last tick.
- R4: A one-cycle watchdog timeout pulse makes reset active at the next clock edge, even with a good supply, and yields one pulse of PULSE ticks.
- R5: A new reset condition during the stretch restarts the count from zero, so a further full PULSE ticks is needed after it clears.
- R6: reset_o is at all times the inverse of reset_n_o.
- R7: low_line_n_o is the inverse of the low-supply flag after a two-flop synchroniser: it changes at the second clock edge after the input changes, one edge before reset reacts, and it is never stretched.
- R8: With the supply above threshold, ce_out_n_o equals ce_in_n_i combinationally (0 = enabled).
- R9: With the supply below threshold, ce_out_n_o is 1 regardless of ce_in_n_i.
- R10: While rst_n is low, reset is active, low_line_n_o is 0 and ce_out_n_o is 1. After release, reset stays active until a full stretch of PULSE ticks has been counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick_i | input | 1 | One-cycle timebase tick that advances the stretch count |
| vcc_low_i | input | 1 | Comparator flag: supply below reset threshold (asynchronous) |
| vcc_below_batt_i | input | 1 | Comparator flag: supply below battery (asynchronous) |
| wdog_expire_i | input | 1 | One-cycle watchdog timeout pulse |
| ce_in_n_i | input | 1 | Memory chip-enable in, active low |
| reset_n_o | output | 1 | Processor reset, active low |
| reset_o | output | 1 | Processor reset, active high |
| low_line_n_o | output | 1 | Supply-low status, active low, not stretched |
| ce_out_n_o | output | 1 | Gated memory chip-enable, active low |

## Verification
The watchdog timeout and the final stretch tick can land on the same clock edge. In that case the new request has to win: the count restarts and the release is cancelled. The bench provokes this by letting a watchdog stretch run to one tick short of completion. It then raises tick and timeout in the same cycle and checks that reset stays active on the following edge. It also checks that a complete fresh run of PULSE ticks is needed before reset is released.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Stretcher phases: condition present, counting out, released
  typedef enum logic [1:0] {
    ST_HOLD    = 2'b00,
    ST_STRETCH = 2'b01,
    ST_IDLE    = 2'b10
  } stretch_st_e;

  function automatic int pick_width(input bit long_sel, input int short_w, input int long_w);
    return long_sel ? long_w : short_w;
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = d_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= {STAGES{RST_VAL}};
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/supv_stretch.sv
module supv_stretch
  import supv_pkg::*;
#(
  parameter int PW_TICKS = 50,
  parameter int CW       = $clog2(PW_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          cond_i,
  output logic          rst_hi_o,
  output logic          rst_lo_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] LAST = CW'(PW_TICKS - 1);

  stretch_st_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          act_d;
  logic          hi_q, lo_q;

  // next-state
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (cond_i) begin
      st_d   = ST_HOLD;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else begin
      unique case (st_q)
        ST_HOLD: begin
          st_d   = ST_STRETCH;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
        ST_STRETCH: begin
          if (tick_i) begin
            cnt_en = 1'b1;
            if (cnt_q == LAST) begin
              st_d  = ST_IDLE;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: begin
          st_d = ST_IDLE;
        end
      endcase
    end
    act_d = (st_d != ST_IDLE);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_HOLD;
      hi_q <= 1'b1;
      lo_q <= 1'b0;
    end else begin
      st_q <= st_d;
      hi_q <= act_d;
      lo_q <= ~act_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign rst_hi_o = hi_q;
  assign rst_lo_o = lo_q;
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter int PULSE_SHORT_TICKS = 50,
  parameter int PULSE_LONG_TICKS  = 200,
  parameter bit LONG_PULSE        = 1'b0,
  parameter int SYNC_STAGES       = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic vcc_low_i,
  input  logic vcc_below_batt_i,
  input  logic wdog_expire_i,
  input  logic ce_in_n_i,
  output logic reset_n_o,
  output logic reset_o,
  output logic low_line_n_o,
  output logic ce_out_n_o
);

  localparam int PW_TICKS = pick_width(LONG_PULSE, PULSE_SHORT_TICKS, PULSE_LONG_TICKS);
  localparam int CW       = $clog2(PW_TICKS + 1);

  logic          rst_sync_n;
  logic [1:0]    flags_s;
  logic          vcc_low_s;
  logic          below_batt_s;
  logic          any_cond;
  logic [CW-1:0] stretch_cnt;

  // reset: asserted asynchronously, released on the clock
  supv_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_sync_n)
  );

  // comparator flags: pessimistic reset value (supply treated as low)
  supv_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_flag_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({vcc_below_batt_i, vcc_low_i}),
    .q_o   (flags_s)
  );

  assign vcc_low_s    = flags_s[0];
  assign below_batt_s = flags_s[1];
  assign any_cond     = vcc_low_s | below_batt_s | wdog_expire_i;

  supv_stretch #(.PW_TICKS(PW_TICKS), .CW(CW)) u_stretch (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick_i   (tick_i),
    .cond_i   (any_cond),
    .rst_hi_o (reset_o),
    .rst_lo_o (reset_n_o),
    .cnt_o    (stretch_cnt)
  );

  assign low_line_n_o = ~vcc_low_s;
  assign ce_out_n_o   = ce_in_n_i | vcc_low_s;

endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk #(
  parameter int PW_TICKS = 50,
  parameter int CW       = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          wdog_expire_i,
  input logic          ce_in_n_i,
  input logic          reset_n_o,
  input logic          reset_o,
  input logic          low_line_n_o,
  input logic          ce_out_n_o,
  input logic [CW-1:0] stretch_cnt
);

  assert_outputs_inverse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reset_o != reset_n_o);

  assert_lowline_holds_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !low_line_n_o |=> !reset_n_o);

  assert_wdog_asserts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_expire_i |=> !reset_n_o);

  assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_expire_i |=> (stretch_cnt == '0));

  assert_release_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_n_o) |-> $past(tick_i));

  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(stretch_cnt) < PW_TICKS);

  assert_ce_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !low_line_n_o |-> ce_out_n_o);

  assert_ce_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    low_line_n_o |-> (ce_out_n_o == ce_in_n_i));

endmodule

bind supv_reset_gen supv_reset_gen_chk #(.PW_TICKS(PW_TICKS), .CW(CW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick_i        (tick_i),
  .wdog_expire_i (wdog_expire_i),
  .ce_in_n_i     (ce_in_n_i),
  .reset_n_o     (reset_n_o),
  .reset_o       (reset_o),
  .low_line_n_o  (low_line_n_o),
  .ce_out_n_o    (ce_out_n_o),
  .stretch_cnt   (stretch_cnt)
);

// File: tb/supv_reset_gen_bench.sv
module supv_reset_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PW         = 50;
  localparam int WD_LIMIT   = 20000;

  logic clk = 1'b0;
  logic rst_n, tick, vcc_low, below_batt, wdog, ce_in_n;
  logic reset_n_o, reset_o, low_line_n_o, ce_out_n_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  supv_reset_gen #(
    .PULSE_SHORT_TICKS (PW),
    .PULSE_LONG_TICKS  (200),
    .LONG_PULSE        (1'b0),
    .SYNC_STAGES       (2)
  ) u_supv_reset_gen (
    .clk              (clk),
    .rst_n            (rst_n),
    .tick_i           (tick),
    .vcc_low_i        (vcc_low),
    .vcc_below_batt_i (below_batt),
    .wdog_expire_i    (wdog),
    .ce_in_n_i        (ce_in_n),
    .reset_n_o        (reset_n_o),
    .reset_o          (reset_o),
    .low_line_n_o     (low_line_n_o),
    .ce_out_n_o       (ce_out_n_o)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  // reset active check, always paired with the R6 complement check
  task automatic check_rst(input string req, input logic exp_active);
    check(req, "reset_n_o", reset_n_o, ~exp_active);
    check("R6", "reset_o", reset_o, exp_active);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic give_ticks(input int n);
    repeat (n) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic wdog_pulse();
    wdog = 1'b1;
    @(negedge clk);
    wdog = 1'b0;
  endtask

  // full stretch out from a released condition, then release
  task automatic run_out(input string req);
    give_ticks(PW - 1);
    check_rst(req, 1'b1);
    give_ticks(1);
    check_rst(req, 1'b0);
  endtask

  task automatic t_power_on();
    step(3);
    check_rst("R10", 1'b1);
    check("R10", "low_line_n_o", low_line_n_o, 1'b0);
    check("R10", "ce_out_n_o", ce_out_n_o, 1'b1);
    rst_n = 1'b1;
    step(8);
    check_rst("R10", 1'b1);
    check("R7", "low_line_n_o", low_line_n_o, 1'b1);
    run_out("R10");
  endtask

  task automatic t_ce_follow();
    ce_in_n = 1'b0;
    #1;
    check("R8", "ce_out_n_o", ce_out_n_o, 1'b0);
    ce_in_n = 1'b1;
    #1;
    check("R8", "ce_out_n_o", ce_out_n_o, 1'b1);
    step(1);
  endtask

  task automatic t_low_supply();
    vcc_low = 1'b1;
    ce_in_n = 1'b0;
    step(1);
    check("R7", "low_line_n_o", low_line_n_o, 1'b1);
    step(1);
    check("R7", "low_line_n_o", low_line_n_o, 1'b0);
    check_rst("R7", 1'b0);
    step(1);
    check_rst("R1", 1'b1);
    check("R9", "ce_out_n_o", ce_out_n_o, 1'b1);
    give_ticks(PW + 10);
    check_rst("R1", 1'b1);
    vcc_low = 1'b0;
    step(1);
    check("R7", "low_line_n_o", low_line_n_o, 1'b0);
    step(1);
    check("R7", "low_line_n_o", low_line_n_o, 1'b1);
    check_rst("R7", 1'b1);
    check("R8", "ce_out_n_o", ce_out_n_o, 1'b0);
    step(2);
    run_out("R3");
    ce_in_n = 1'b1;
  endtask

  task automatic t_below_batt();
    below_batt = 1'b1;
    ce_in_n    = 1'b0;
    step(4);
    check_rst("R2", 1'b1);
    check("R2", "low_line_n_o", low_line_n_o, 1'b1);
    check("R2", "ce_out_n_o", ce_out_n_o, 1'b0);
    give_ticks(PW + 5);
    check_rst("R2", 1'b1);
    below_batt = 1'b0;
    ce_in_n    = 1'b1;
    step(4);
    run_out("R2");
  endtask

  task automatic t_watchdog();
    check_rst("R4", 1'b0);
    wdog_pulse();
    check_rst("R4", 1'b1);
    check("R4", "low_line_n_o", low_line_n_o, 1'b1);
    step(1);
    run_out("R4");
  endtask

  task automatic t_restart();
    wdog_pulse();
    step(1);
    give_ticks(20);
    check_rst("R5", 1'b1);
    wdog_pulse();
    step(1);
    run_out("R5");
  endtask

  // timeout and the final tick fall in one cycle: request wins
  task automatic t_same_cycle();
    wdog_pulse();
    step(1);
    give_ticks(PW - 1);
    check_rst("R5", 1'b1);
    tick = 1'b1;
    wdog = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    wdog = 1'b0;
    check_rst("R5", 1'b1);
    step(1);
    run_out("R5");
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    rst_n      = 1'b0;
    tick       = 1'b0;
    vcc_low    = 1'b0;
    below_batt = 1'b0;
    wdog       = 1'b0;
    ce_in_n    = 1'b1;
    t_power_on();
    t_ce_follow();
    t_low_supply();
    t_below_batt();
    t_watchdog();
    t_restart();
    t_same_cycle();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule